// File: doc/BRIEF.md
# DMA Transfer Count Register Bank

This block holds the transfer counts for four DMA channels. Each channel has a 16-bit count with two stages: a master stage that software programs, and a working down-counter that the DMA engine consumes. Software writes and reads the counts over a simple 16-bit register bus. The DMA engine raises a per-channel `xfer_done` strobe once for each completed transfer.

A count is programmed as the number of transfers minus one. The working stage steps down by one on every strobe. The strobe that finds the working stage at zero is the terminal count. On that strobe the block pulses `tc_pulse` for the channel and reloads the working stage from the master stage, so the channel is ready to restart. Because the stages are separate, software can program the next count while a transfer sequence is still running.

Top module: `dma_count_bank`

## Requirements
- R1: After a synchronous reset, every master stage, working stage and active flag is zero, and a read of any channel returns 0000h.
- R2: Channel k is addressed at byte offset 2k (bus_addr[2:1] = k). An access with bus_addr[0] = 1 is not a whole halfword: a write with it changes nothing, and a read with it returns 0000h.
- R3: Each `xfer_done` strobe on a channel whose working stage is not zero lowers that working stage by exactly 1 at the next edge.
- R4: `tc_pulse[k]` is high in exactly those cycles where `xfer_done[k]` is high and working stage k is 0000h. A programmed value V therefore gives its terminal count on the (V+1)th strobe: 0000h gives 1 transfer, FFFFh gives 65,536.
- R5: On terminal count, the working stage loads the value the master stage held before that edge.
- R6: A write to an idle channel loads both the master stage and the working stage with the written data.
- R7: A write to an active channel loads only the master stage. The running count is left unchanged.
- R8: When a write and `xfer_done` hit the same channel in the same cycle, the working stage decrements or reloads as for the strobe alone, and the write lands in the master stage only.
- R9: A channel becomes active on a strobe that is not a terminal count, and becomes idle on a terminal count.
- R10: A read with bus_sel high and bus_wr low returns the addressed channel's working stage in the same cycle. With bus_sel low, bus_rdata is 0000h.
- R11: Strobes and writes on one channel leave every other channel's stages unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset within the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| xfer_done | input | 4 | Per-channel transfer-completed strobe |
| tc_pulse | output | 4 | Per-channel terminal-count pulse |

## Verification
Embedded properties check, on every cycle, the edge-by-edge rules of each channel:
- a strobe decrements the working stage or reloads it from the master stage;
- the working stage holds when there is no strobe and no idle write;
- a write to an active channel leaves the running count alone;
- at most one channel's write enable rises for any address.

Only the bench's scenarios can show behaviour that spans many cycles:
- a programmed value of V yields exactly V+1 transfers before terminal count;
- a count written mid-run takes effect only after the following terminal count;
- a same-cycle collision on an idle channel reloads the old master value;
- the channels stay independent.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    parameter int NUM_CH   = 4;
    parameter int CNT_W    = 16;
    parameter int ADDR_W   = 3;
    localparam int IDX_W   = $clog2(NUM_CH);

    typedef logic [CNT_W-1:0] cnt_t;

    // One channel's view of a bus write this cycle
    typedef struct packed {
        logic en;
        cnt_t data;
    } ch_write_t;

    // Stage contents of one channel
    typedef struct packed {
        cnt_t master;
        cnt_t work;
        logic active;
    } ch_state_t;

    function automatic logic at_terminal(input cnt_t c);
        return c == '0;
    endfunction
endpackage

// File: rtl/dtc_addr_decode.sv
module dtc_addr_decode
    import dtc_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int AW   = ADDR_W,
    localparam int IW  = $clog2(N_CH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output logic [N_CH-1:0] wr_en,
    output logic          rd_ok,
    output logic [IW-1:0] rd_idx
);
    logic aligned;
    assign aligned = ~bus_addr[0];
    assign rd_idx  = bus_addr[IW:1];
    assign rd_ok   = bus_sel & ~bus_wr & aligned;

    for (genvar k = 0; k < N_CH; k++) begin : g_dec
        assign wr_en[k] = bus_sel & bus_wr & aligned & (bus_addr[IW:1] == k[IW-1:0]);
    end

    // R2: never more than one channel written per access
    p_one_write_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));
    // R2: an unaligned address never produces a write
    p_unaligned_drop_r2: assert property (@(posedge clk) disable iff (rst)
        bus_addr[0] |-> (wr_en == '0));
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
    import dtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ch_write_t wr,
    input  logic      done,
    output cnt_t      work_q,
    output logic      tc
);
    ch_state_t st, st_nxt;
    logic      term;

    assign term   = at_terminal(st.work);
    assign tc     = done & term;
    assign work_q = st.work;

    always_comb begin
        st_nxt = st;
        if (wr.en) st_nxt.master = wr.data;
        if (done) begin
            if (term) begin
                st_nxt.work   = st.master;   // reload uses pre-edge master
                st_nxt.active = 1'b0;
            end else begin
                st_nxt.work   = st.work - 1'b1;
                st_nxt.active = 1'b1;
            end
        end else if (wr.en && !st.active) begin
            st_nxt.work = wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    // R3: non-terminal strobe lowers the count by one
    p_dec_by_one_r3: assert property (@(posedge clk) disable iff (rst)
        (done && st.work != '0) |=> (st.work == $past(st.work) - 1'b1));
    // R5: terminal strobe reloads from the master stage held before the edge
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (done && st.work == '0) |=> (st.work == $past(st.master)));
    // R7: write to an active channel leaves the running count alone
    p_active_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr.en && st.active && !done) |=> $stable(st.work));
    // R6: write to an idle channel loads the working stage
    p_idle_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !st.active && !done) |=> (st.work == $past(wr.data)));
    // R8: any write lands in the master stage, even alongside a strobe
    p_master_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (st.master == $past(wr.data)));
    // R11: no strobe and no write means nothing moves
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!done && !wr.en) |=> ($stable(st.work) && $stable(st.master)));
    // R9: a terminal count leaves the channel idle
    p_idle_after_tc_r9: assert property (@(posedge clk) disable iff (rst)
        tc |=> !st.active);
endmodule

// File: rtl/dma_count_bank.sv
module dma_count_bank
    import dtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0]    xfer_done,
    output logic [NUM_CH-1:0]    tc_pulse
);
    logic [NUM_CH-1:0] wr_en;
    logic              rd_ok;
    logic [IDX_W-1:0]  rd_idx;
    cnt_t              work [NUM_CH];

    dtc_addr_decode #(.N_CH(NUM_CH), .AW(ADDR_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_en   (wr_en),
        .rd_ok   (rd_ok),
        .rd_idx  (rd_idx)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        ch_write_t w;
        assign w.en   = wr_en[k];
        assign w.data = bus_wdata;
        dtc_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr    (w),
            .done  (xfer_done[k]),
            .work_q(work[k]),
            .tc    (tc_pulse[k])
        );
    end

    assign bus_rdata = rd_ok ? work[rd_idx] : '0;

    // R4: a terminal pulse only accompanies its own strobe
    p_tc_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        ((tc_pulse & ~xfer_done) == '0));
    // R10: idle bus drives zero
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/dma_count_bank_bench.sv
module dma_count_bank_bench;
    import dtc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  xfer_done = '0;
    logic [3:0]  tc_pulse;

    always #2.5 clk = ~clk;   // 200 MHz

    dma_count_bank u_dma_count_bank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .tc_pulse(tc_pulse)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t rq[$];

    // Requirement-level model
    logic [15:0] m_master [4];
    logic [15:0] m_work   [4];
    logic        m_active [4];

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data against queued expectations
    always @(negedge clk) begin
        if (!rst && bus_sel && !bus_wr && rq.size() > 0) begin
            rd_item_t it;
            it = rq.pop_front();
            check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
        end
    end

    // One clock of stimulus. Checks tc at negedge and advances the model.
    task automatic step(input logic sel, input logic wr, input logic [2:0] addr,
                        input logic [15:0] wd, input logic [3:0] done,
                        input string tag);
        logic [3:0] exp_tc;
        logic [3:0] wen;
        @(posedge clk); #1;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd; xfer_done = done;
        for (int k = 0; k < 4; k++) begin
            exp_tc[k] = done[k] && (m_work[k] == 16'h0);
            wen[k]    = sel && wr && !addr[0] && (addr[2:1] == k[1:0]);
        end
        @(negedge clk);
        check(tc_pulse == exp_tc, {tag, " R4 tc"}, {12'h0, tc_pulse}, {12'h0, exp_tc});
        for (int k = 0; k < 4; k++) begin
            logic [15:0] old_master;
            old_master = m_master[k];
            if (wen[k]) m_master[k] = wd;
            if (done[k]) begin
                if (m_work[k] == 16'h0) begin
                    m_work[k] = old_master; m_active[k] = 1'b0;
                end else begin
                    m_work[k] = m_work[k] - 16'h1; m_active[k] = 1'b1;
                end
            end else if (wen[k] && !m_active[k]) begin
                m_work[k] = wd;
            end
        end
    endtask

    task automatic wr_ch(input int ch, input logic [15:0] d, input string tag);
        step(1'b1, 1'b1, 3'(ch*2), d, 4'h0, tag);
    endtask

    task automatic strobe(input int ch, input string tag);
        step(1'b0, 1'b0, 3'h0, 16'h0, 4'(1 << ch), tag);
    endtask

    // Driver: queues the model's expected value, then issues the read
    task automatic rd_ch(input int ch, input string tag);
        rd_item_t it;
        it.exp = m_work[ch];
        it.tag = tag;
        rq.push_back(it);
        step(1'b1, 1'b0, 3'(ch*2), 16'h0, 4'h0, tag);
    endtask

    task automatic idle_cycle;
        step(1'b0, 1'b0, 3'h0, 16'h0, 4'h0, "idle");
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_master[k] = '0; m_work[k] = '0; m_active[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int k = 0; k < 4; k++) rd_ch(k, "R1 reset read");

        // R10: unselected bus returns zero
        idle_cycle();
        check(bus_rdata == 16'h0, "R10 idle rdata", bus_rdata, 16'h0);

        // R6 / R2: idle write loads working stage, at offset 2
        wr_ch(1, 16'h0003, "R6 idle write");
        rd_ch(1, "R6 idle write readback");
        rd_ch(0, "R11 ch0 untouched");

        // R2: unaligned write ignored, unaligned read gives zero
        step(1'b1, 1'b1, 3'd3, 16'hAAAA, 4'h0, "R2 odd write");
        rd_ch(1, "R2 odd write ignored");
        step(1'b1, 1'b0, 3'd3, 16'h0, 4'h0, "R2 odd read");
        check(bus_rdata == 16'h0, "R2 odd read zero", bus_rdata, 16'h0);

        // R3 / R4: value 3 gives four transfers
        for (int i = 0; i < 3; i++) strobe(1, "R3 decrement");
        rd_ch(1, "R3 count at zero");
        strobe(1, "R4 terminal");
        rd_ch(1, "R5 reload");

        // R7: write during activity touches master only
        wr_ch(2, 16'h0005, "R7 setup");
        strobe(2, "R9 activate");
        wr_ch(2, 16'h0009, "R7 active write");
        rd_ch(2, "R7 running count kept");
        for (int i = 0; i < 4; i++) strobe(2, "R3 ch2 run");
        strobe(2, "R4 ch2 terminal");
        rd_ch(2, "R5 reload new master");
        rd_ch(1, "R11 ch1 unaffected");

        // R9: channel idle after tc, so a write loads working stage again
        wr_ch(2, 16'h0002, "R9 idle again");
        rd_ch(2, "R9 idle write after tc");

        // R8: collision on active channel
        wr_ch(3, 16'h0002, "R8 setup");
        strobe(3, "R8 activate");
        step(1'b1, 1'b1, 3'd6, 16'h0007, 4'b1000, "R8 collision");
        rd_ch(3, "R8 strobe wins");
        strobe(3, "R8 terminal");
        rd_ch(3, "R8 reload written master");

        // R8: collision on idle channel at zero: reload uses old master
        step(1'b1, 1'b1, 3'd0, 16'h0005, 4'b0001, "R8 idle collision");
        rd_ch(0, "R8 old master reloaded");
        strobe(0, "R8 second terminal");
        rd_ch(0, "R8 new master reloaded");

        // R4 boundary: FFFF is not terminal
        wr_ch(0, 16'hFFFF, "R4 max setup");
        rd_ch(0, "R4 max readback");
        strobe(0, "R4 max first strobe");
        rd_ch(0, "R3 max decrement");

        // R11: simultaneous strobes on separate channels
        step(1'b0, 1'b0, 3'h0, 16'h0, 4'b0110, "R11 multi strobe");
        for (int k = 0; k < 4; k++) rd_ch(k, "R11 multi readback");

        // R1: reset clears again
        @(posedge clk); #1 rst = 1'b1;
        bus_sel = 1'b0; xfer_done = '0;
        @(posedge clk); #1 rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            m_master[k] = '0; m_work[k] = '0; m_active[k] = 1'b0;
        end
        for (int k = 0; k < 4; k++) rd_ch(k, "R1 second reset");
        strobe(2, "R1 master cleared");
        rd_ch(2, "R1 reload zero");

        idle_cycle();
        check(rq.size() == 0, "queue drained", 16'(rq.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule